// File: doc/BRIEF.md
# Upstream Word-Clock Phase Selector

This block serves the contra-directional clocking mode of a 16:1 serializer. It divides the fast bit clock by sixteen. From that count it produces a word-rate clock with an even duty cycle, which goes back to the upstream data source so that the source can launch parallel words toward the serializer. A two-bit phase control moves the rising and falling edges of that returned clock in quarter-period steps. Board designers use it to meet input setup and hold for a given trace length and upstream delay.

The block also produces the internal load strobe, one fast cycle wide and once per word. The strobe marks the instant at which the parallel input is captured. It is decoded from the divider count alone, so it stays at the same count whatever phase is selected. When the mode select is low (the clockless transfer mode), the returned clock is held low and the strobe keeps running. Both outputs are registered on the fast clock, and reset is asynchronous and active-low.

Top module: `cc_contra_clk`

## Requirements
- R1: While `rst_n` is low, `word_clk` and `load_strobe` are both 0, and the divider count is 0.
- R2: In contra mode with a fixed setting, `word_clk` repeats every 16 fast cycles. In each period it is high for 8 cycles and low for 8.
- R3: With `phase_sel` = 2'b11 (0 degrees), `word_clk` is 1 after edges whose count modulo 16 is 0 to 7, and 0 after counts 8 to 15. Its falling edge therefore lands in the same cycle as `load_strobe`. Count k means the k-th rising edge of `clk` after `rst_n` rises.
- R4: The settings 2'b10, 2'b01 and 2'b00 delay `word_clk` by 4, 8 and 12 fast cycles relative to setting 2'b11. These delays are -90, -180 and -270 degrees.
- R5: `load_strobe` is 1 for exactly one fast cycle in every 16, after edges whose count modulo 16 is 8, under every phase setting and under both modes.
- R6: A change of `phase_sel` takes effect at the next rising edge. It does not move the count or the strobe cadence, even when it coincides with the strobe cycle.
- R7: When `contra_mode` is 0 at a rising edge, `word_clk` is 0 after that edge.
- R8: After reset is released, the first `load_strobe` pulse follows the 8th rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| contra_mode | input | 1 | 1 = returned word clock enabled (contra mode), 0 = held low |
| phase_sel | input | 2 | Phase of the returned clock: 11 = 0, 10 = -90, 01 = -180, 00 = -270 degrees |
| word_clk | output | 1 | Word-rate clock sent upstream |
| load_strobe | output | 1 | One-cycle pulse per word marking the input capture instant |

## Verification
The two functions that can fall in the same cycle are a phase change of the returned clock and the load strobe. The bench waits until the count reaches 7 and then rewrites `phase_sel`, so the new setting is first taken at the strobe edge. It then checks, cycle by cycle, that the clock adopts the new delay at once and that the strobe still fires at count 8 and every 16 cycles after. The same judgement is repeated with the mode switched off across a strobe. In that case the clock must stay low while the strobe cadence continues unchanged.

// File: rtl/cc_phase_pkg.sv
package cc_phase_pkg;

  // Number of quarter-steps of delay requested by a phase code:
  // the highest code means no delay, each lower code one more step.
  function automatic int lag_of(int sel, int phases);
    return phases - 1 - sel;
  endfunction

  // Level of the divided clock at count cnt when delayed by lag steps
  // of step fast cycles; high during the first half of the period.
  function automatic logic wave_level(int cnt, int lag, int step, int div);
    int pos;
    pos = (cnt + div - ((lag * step) % div)) % div;
    return logic'(pos < (div / 2));
  endfunction

  // Capture instant: fixed at the half-period count.
  function automatic logic strobe_hit(int cnt, int div);
    return logic'(cnt == (div / 2));
  endfunction

endpackage

// File: rtl/cc_div_counter.sv
module cc_div_counter #(
  parameter int DIV = 16,
  localparam int CNT_W = $clog2(DIV)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_nxt
);

  logic [CNT_W-1:0] cnt_q;

  assign cnt_nxt = (cnt_q == CNT_W'(DIV - 1)) ? '0 : cnt_q + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

endmodule

// File: rtl/cc_phase_bank.sv
module cc_phase_bank #(
  parameter int DIV    = 16,
  parameter int PHASES = 4,
  localparam int CNT_W = $clog2(DIV),
  localparam int SEL_W = $clog2(PHASES),
  localparam int STEP  = DIV / PHASES
) (
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [SEL_W-1:0] phase_sel,
  output logic             phase_level
);

  logic [PHASES-1:0] wave;
  logic [SEL_W-1:0]  lag_idx;

  // One candidate waveform per phase step; the selector only picks one.
  for (genvar p = 0; p < PHASES; p++) begin : g_wave
    assign wave[p] = cc_phase_pkg::wave_level(int'(cnt_nxt), p, STEP, DIV);
  end

  assign lag_idx     = SEL_W'(cc_phase_pkg::lag_of(int'(phase_sel), PHASES));
  assign phase_level = wave[lag_idx];

endmodule

// File: rtl/cc_load_strobe.sv
module cc_load_strobe #(
  parameter int DIV = 16,
  localparam int CNT_W = $clog2(DIV)
) (
  input  logic [CNT_W-1:0] cnt_nxt,
  output logic             sample_evt
);

  assign sample_evt = cc_phase_pkg::strobe_hit(int'(cnt_nxt), DIV);

endmodule

// File: rtl/cc_contra_clk.sv
module cc_contra_clk #(
  parameter int DIV    = 16,
  parameter int PHASES = 4,
  localparam int CNT_W = $clog2(DIV),
  localparam int SEL_W = $clog2(PHASES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             contra_mode,
  input  logic [SEL_W-1:0] phase_sel,
  output logic             word_clk,
  output logic             load_strobe
);

  logic [CNT_W-1:0] cnt_nxt;
  logic             phase_level;
  logic             sample_evt;

  cc_div_counter #(.DIV(DIV)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_nxt (cnt_nxt)
  );

  cc_phase_bank #(.DIV(DIV), .PHASES(PHASES)) u_bank (
    .cnt_nxt     (cnt_nxt),
    .phase_sel   (phase_sel),
    .phase_level (phase_level)
  );

  cc_load_strobe #(.DIV(DIV)) u_strb (
    .cnt_nxt    (cnt_nxt),
    .sample_evt (sample_evt)
  );

  // Outputs are flops so the clock leaving the block has no decode glitches.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_clk    <= 1'b0;
      load_strobe <= 1'b0;
    end else begin
      word_clk    <= contra_mode & phase_level;
      load_strobe <= sample_evt;
    end
  end

endmodule

// File: rtl/cc_contra_clk_chk.sv
module cc_contra_clk_chk #(
  parameter int DIV    = 16,
  parameter int PHASES = 4,
  localparam int SEL_W = $clog2(PHASES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             contra_mode,
  input logic [SEL_W-1:0] phase_sel,
  input logic             word_clk,
  input logic             load_strobe,
  input logic             sample_evt
);

  int unsigned gap;
  int unsigned since;
  logic        seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap   <= 0;
      since <= 0;
      seen  <= 1'b0;
    end else begin
      if (since < 100000) since <= since + 1;
      if (load_strobe) begin
        gap  <= 1;
        seen <= 1'b1;
      end else begin
        gap <= gap + 1;
      end
    end
  end

  // R1
  always @(negedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!word_clk && !load_strobe);
    end
  end

  // R3
  fall_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(word_clk) && $past(phase_sel) == '1 && $past(phase_sel, 2) == '1
     && $past(contra_mode) && $past(contra_mode, 2)) |-> load_strobe);

  // R5
  strobe_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_strobe && seen) |-> gap == DIV);

  // R5
  strobe_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |=> load_strobe);

  // R7
  mode_off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !contra_mode |=> !word_clk);

  // R8
  first_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_strobe && !seen) |-> since == DIV / 2);

endmodule

bind cc_contra_clk cc_contra_clk_chk #(.DIV(DIV), .PHASES(PHASES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .contra_mode (contra_mode),
  .phase_sel   (phase_sel),
  .word_clk    (word_clk),
  .load_strobe (load_strobe),
  .sample_evt  (sample_evt)
);

// File: tb/sim_cc_contra_clk.sv
module sim_cc_contra_clk;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       contra_mode = 1'b1;
  logic [1:0] phase_sel = 2'b11;
  logic       word_clk;
  logic       load_strobe;

  int n_checks = 0;
  int n_fail   = 0;
  int edges;
  bit done = 1'b0;

  cc_contra_clk u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .contra_mode (contra_mode),
    .phase_sel   (phase_sel),
    .word_clk    (word_clk),
    .load_strobe (load_strobe)
  );

  always #(CLK_P / 2) clk = ~clk;

  // Bench-side edge count since reset release.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) edges <= 0;
    else        edges <= edges + 1;
  end

  function automatic logic exp_word(int e, logic m, logic [1:0] s);
    int delay;
    int pos;
    case (s)
      2'b11:   delay = 0;
      2'b10:   delay = 4;
      2'b01:   delay = 8;
      default: delay = 12;
    endcase
    pos = ((e % 16) - delay + 16) % 16;
    return m && (pos < 8);
  endfunction

  function automatic logic exp_strobe(int e);
    return (e > 0) && ((e % 16) == 8);
  endfunction

  task automatic check_bit(string req, string what, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at edge %0d: got %0b expected %0b", req, what, edges, act, exp);
    end
  endtask

  task automatic check_cycle(string req);
    @(negedge clk);
    check_bit(req, "word_clk", word_clk, exp_word(edges, contra_mode, phase_sel));
    check_bit(req, "load_strobe", load_strobe, exp_strobe(edges));
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check_bit("R1", "word_clk in reset", word_clk, 1'b0);
      check_bit("R1", "load_strobe in reset", load_strobe, 1'b0);
    end
    rst_n = 1'b1;
  endtask

  task automatic t_reset_and_first();
    contra_mode = 1'b1;
    phase_sel   = 2'b11;
    apply_reset();
    for (int i = 1; i <= 8; i++) begin
      check_cycle("R8");
      if (i < 8) check_bit("R8", "early strobe", load_strobe, 1'b0);
      else       check_bit("R8", "first strobe", load_strobe, 1'b1);
    end
  endtask

  task automatic t_zero_phase();
    int highs;
    int rises;
    logic prev;
    highs = 0;
    rises = 0;
    prev  = word_clk;
    for (int i = 0; i < 32; i++) begin
      check_cycle("R3");
      if (i >= 16) begin
        if (word_clk) highs++;
        if (word_clk && !prev) rises++;
      end
      prev = word_clk;
    end
    check_bit("R2", "8 high cycles per period", logic'(highs == 8), 1'b1);
    check_bit("R2", "one rising edge per period", logic'(rises == 1), 1'b1);
  endtask

  task automatic t_other_phases();
    logic [1:0] codes [3] = '{2'b10, 2'b01, 2'b00};
    for (int k = 0; k < 3; k++) begin
      int strobes;
      strobes = 0;
      phase_sel = codes[k];
      for (int i = 0; i < 32; i++) begin
        check_cycle("R4");
        if (load_strobe) strobes++;
      end
      check_bit("R5", "two strobes in 32 cycles", logic'(strobes == 2), 1'b1);
    end
  endtask

  task automatic t_switch_on_strobe();
    phase_sel = 2'b11;
    while ((edges % 16) != 7) check_cycle("R6");
    phase_sel = 2'b01;
    check_cycle("R6");
    check_bit("R6", "strobe kept at count 8", load_strobe, 1'b1);
    repeat (20) check_cycle("R6");
    while ((edges % 16) != 7) check_cycle("R6");
    phase_sel = 2'b10;
    repeat (18) check_cycle("R6");
  endtask

  task automatic t_mode_off();
    int strobes;
    strobes = 0;
    while ((edges % 16) != 7) check_cycle("R7");
    contra_mode = 1'b0;
    for (int i = 0; i < 32; i++) begin
      check_cycle("R7");
      check_bit("R7", "parked low", word_clk, 1'b0);
      if (load_strobe) strobes++;
    end
    check_bit("R5", "strobe runs in mode 0", logic'(strobes == 2), 1'b1);
    contra_mode = 1'b1;
    phase_sel   = 2'b00;
    repeat (16) check_cycle("R7");
  endtask

  task automatic t_reset_again();
    apply_reset();
    repeat (24) check_cycle("R8");
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    t_reset_and_first();
    t_zero_phase();
    t_other_phases();
    t_switch_on_strobe();
    t_mode_off();
    t_reset_again();
    done = 1'b1;
    finish_up();
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got hang expected completion");
      finish_up();
    end
  end

endmodule